// File: doc/BRIEF.md
# Addressed Serial Octal Latch Front End

This block is the digital side of an eight-channel converter. A host sends 16-bit words over a three-wire serial port made of a serial clock, serial data and an active-low frame strobe. Each word carries a 12-bit code, a channel selector and one device-address bit. The block compares the address bit with a strap input, so two devices can share the same port. If the bit matches, the code goes into the selected channel's input latch. A separate active-low load input copies all eight input latches into the output latches in the same cycle. An active-low clear zeroes the output latches and leaves the input latches untouched, so a later load brings the old codes back.

After sixteen bits the shift register locks. It stays locked until the frame strobe falls again. The captured word is then sent back out on a serial output, one bit per rising serial-clock edge, so that devices can be chained. Each output code also drives a segmented switch vector. The upper two bits become three equal-weight thermometer enables, and the lower ten bits become binary-weighted switch lines. All serial and control pins are asynchronous to the block's system clock. They pass through synchronisers, and serial-clock and frame edges are detected as single-cycle pulses. The system clock must run at least four times faster than the serial clock.

Top module: `serial_octal_latch`

## Requirements
- R1: Serial data is sampled MSB first, one bit per falling edge of `ser_clk`. In the word, bits [15:4] hold the 12-bit code, bit 3 holds the device address and bits [2:0] hold the channel index.
- R2: After 16 bits have been captured, more `ser_clk` falling edges change nothing until the next falling edge of `frame_n`.
- R3: Starting at the first rising edge of `ser_clk` after a capture, `ser_dout` presents the captured word MSB first, one bit per rising edge.
- R4: A captured word whose bit 3 differs from `dev_addr` is discarded, and no input latch changes.
- R5: While `load_n` is low and `clear_n` is high, all output latches take their input latches' values together. With `load_n` high, writing an input latch does not move `code_out`.
- R6: While `clear_n` is low, every output code is zero. The input latches keep their values, so a later load restores the previous codes.
- R7: When `clear_n` and `load_n` are both low, the clear wins.
- R8: Channel c drives `seg_en[3c+2:3c]` from code bits [11:10] as a thermometer: 00 gives 000, 01 gives 001, 10 gives 011 and 11 gives 111. `bin_en[10c+9:10c]` equals code bits [9:0]. `code_out[12c+11:12c]` is channel c's output code.
- R9: After reset, all latches are zero and `ser_dout` is 0. The shift register stays locked until a falling edge of `frame_n` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| frame_n | input | 1 | Active-low frame strobe, asynchronous |
| ser_din | input | 1 | Serial data input |
| dev_addr | input | 1 | Device address strap |
| load_n | input | 1 | Active-low global load of output latches |
| clear_n | input | 1 | Active-low clear of output latches |
| ser_dout | output | 1 | Serial echo output for daisy chaining |
| code_out | output | 96 | Output latch codes, 12 bits per channel |
| seg_en | output | 24 | Thermometer segment enables, 3 per channel |
| bin_en | output | 80 | Binary-weighted switch lines, 10 per channel |

## Verification
The bench builds the block with its default parameters: eight channels, 12-bit codes and a two-flop synchroniser, which gives a 16-bit word with the address at bit 3. With these values every channel index, both address-strap polarities and all four segment-decode levels are reachable with a few words. The serial clock is driven at eight system cycles per period, so the latency from each synchroniser to the output registers stays inside one half-period of the serial clock.

// File: rtl/sol_pkg.sv
// Package for the addressed serial octal latch.
// Holds the default sizes and the bit positions of the synchronised pin bundle.
package sol_pkg;
    localparam int SOL_CHANNELS    = 8;
    localparam int SOL_CODE_W      = 12;
    localparam int SOL_SEG_BITS    = 2;
    localparam int SOL_SYNC_STAGES = 2;

    // Positions of each asynchronous pin inside the synchroniser bundle.
    typedef enum int {
        PIN_SCLK  = 0,
        PIN_FRAME = 1,
        PIN_DATA  = 2,
        PIN_ADDR  = 3,
        PIN_LOAD  = 4,
        PIN_CLEAR = 5,
        PIN_COUNT = 6
    } sol_pin_e;
endpackage

// File: rtl/sol_sync.sv
// Multi-bit synchroniser.
// Each bit passes through STAGES flops on its own. Bits are treated as independent
// levels, and no bus coherence is assumed. Reset loads RST_VAL into every stage.
module sol_sync #(
    parameter int            N       = 1,
    parameter int            STAGES  = 2,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] q
);
    logic [N-1:0] chain_q [STAGES];

    // Shift pin levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sol_shifter.sv
// Serial receive and echo engine.
// It takes synchronised serial clock, frame and data levels and finds their edges.
// It captures WORD_W bits MSB first on serial-clock falls and then locks until the next
// frame fall. The captured word is shifted back out on rising serial-clock edges.
// Assumes the system clock is at least 4x the serial clock.
module sol_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              frame_s,
    input  logic              sdata_s,
    output logic [WORD_W-1:0] word,
    output logic              word_done,
    output logic              sdout
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic              sclk_prev_q, frame_prev_q;
    logic              sclk_fall, sclk_rise, frame_fall;
    logic [WORD_W-1:0] sh_q, echo_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              locked_q, done_q, echo_en_q, sdout_q;

    // Hold the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q  <= 1'b1;
            frame_prev_q <= 1'b0;
        end else begin
            sclk_prev_q  <= sclk_s;
            frame_prev_q <= frame_s;
        end
    end

    assign sclk_fall  = sclk_prev_q & ~sclk_s;
    assign sclk_rise  = ~sclk_prev_q & sclk_s;
    assign frame_fall = frame_prev_q & ~frame_s;

    // Capture bits, count to a full word, then lock until a frame fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            locked_q <= 1'b1;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (frame_fall) begin
                cnt_q    <= '0;
                locked_q <= 1'b0;
            end else if (sclk_fall && !locked_q) begin
                sh_q <= {sh_q[WORD_W-2:0], sdata_s};
                if (cnt_q == CNT_W'(WORD_W - 1)) begin
                    cnt_q    <= '0;
                    locked_q <= 1'b1;
                    done_q   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Load the echo register on capture and shift it out on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            echo_q    <= '0;
            echo_en_q <= 1'b0;
            sdout_q   <= 1'b0;
        end else if (frame_fall) begin
            echo_en_q <= 1'b0;
        end else if (done_q) begin
            echo_q    <= sh_q;
            echo_en_q <= 1'b1;
        end else if (sclk_rise && echo_en_q) begin
            sdout_q <= echo_q[WORD_W-1];
            echo_q  <= {echo_q[WORD_W-2:0], 1'b0};
        end
    end

    assign word      = sh_q;
    assign word_done = done_q;
    assign sdout     = sdout_q;

    // R2: once locked, the shift register is frozen until a frame fall.
    assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && !frame_fall) |=> $stable(sh_q));

    // R1: an accepted falling edge lands the sampled data bit in the LSB.
    assert_sample_lsb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && !locked_q && !frame_fall) |=> (sh_q[0] == $past(sdata_s)));

    // R3: completion hands the whole word to the echo register.
    assert_echo_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !frame_fall) |=> (echo_q == $past(sh_q)));
endmodule

// File: rtl/sol_latch_bank.sv
// Double-buffered latch bank.
// An accepted word writes one input latch when its address bit matches the strap.
// Load copies every input latch to its output latch in one cycle. Clear zeroes the
// output latches only and wins over load. All control inputs are already synchronised.
module sol_latch_bank #(
    parameter int CH     = 8,
    parameter int CODE_W = 12,
    parameter int SEL_W  = 3,
    parameter int WORD_W = CODE_W + SEL_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         word_done,
    input  logic [WORD_W-1:0]            word,
    input  logic                         dev_addr,
    input  logic                         load_n,
    input  logic                         clear_n,
    output logic [CH-1:0][CODE_W-1:0]    out_codes
);
    localparam int ADDR_BIT = SEL_W;

    logic [CH-1:0][CODE_W-1:0] in_q, out_q;
    logic [SEL_W-1:0]          sel;
    logic                      hit;

    assign sel = word[SEL_W-1:0];
    assign hit = word_done && (word[ADDR_BIT] == dev_addr) && (int'(sel) < CH);

    // Write the selected input latch from an accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else if (hit) in_q[sel] <= word[WORD_W-1 -: CODE_W];
    end

    // Update the output latches: clear first, then a global load.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_q <= '0;
        else if (!clear_n) out_q <= '0;
        else if (!load_n)  out_q <= in_q;
    end

    assign out_codes = out_q;

    // R4: a word with a mismatched address bit leaves the input latches alone.
    assert_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && (word[ADDR_BIT] != dev_addr)) |=> $stable(in_q));

    // R5: a load without clear copies every input latch at once.
    assert_load_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && !load_n) |=> (out_q == $past(in_q)));

    // R6: a clear zeroes the outputs and R7: it overrides a simultaneous load.
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_n) |=> (out_q == '0));
    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_n && !load_n) |=> (out_q == '0));

    // R6: a clear does not touch the input latches.
    assert_clear_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_n && !word_done) |=> $stable(in_q));
endmodule

// File: rtl/sol_segdec.sv
// Per-channel segmented switch decoder.
// The top SEG_BITS of each code become a thermometer over SEG_N equal-weight enables.
// The remaining low bits pass straight through as binary-weighted switch lines. Purely
// combinational. The clock and reset exist only for the guarding property.
module sol_segdec #(
    parameter int CH       = 8,
    parameter int CODE_W   = 12,
    parameter int SEG_BITS = 2,
    parameter int SEG_N    = (1 << SEG_BITS) - 1,
    parameter int LOW_W    = CODE_W - SEG_BITS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CH-1:0][CODE_W-1:0]  codes,
    output logic [CH-1:0][SEG_N-1:0]   seg_en,
    output logic [CH-1:0][LOW_W-1:0]   bin_en
);
    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic [SEG_BITS-1:0] top;
        assign top = codes[c][CODE_W-1 -: SEG_BITS];

        // Each segment enable turns on once the top field exceeds its index.
        for (genvar k = 0; k < SEG_N; k++) begin : g_seg
            assign seg_en[c][k] = (int'(top) > k);
        end

        assign bin_en[c] = codes[c][LOW_W-1:0];

        // R8: the number of active segments equals the top-field value.
        assert_thermo_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(seg_en[c]) == int'(top)));
    end
endmodule

// File: rtl/serial_octal_latch.sv
// Top of the addressed serial octal latch front end.
// It synchronises the asynchronous pins, receives and echoes serial words, writes
// the addressed input latch, moves the latch bank on load or clear, and decodes each
// output code into switch drives. Assumes clk is at least 4x the serial clock.
module serial_octal_latch
    import sol_pkg::*;
#(
    parameter int CHANNELS    = SOL_CHANNELS,
    parameter int CODE_W      = SOL_CODE_W,
    parameter int SEG_BITS    = SOL_SEG_BITS,
    parameter int SYNC_STAGES = SOL_SYNC_STAGES,
    parameter int SEL_W       = $clog2(CHANNELS),
    parameter int SEG_N       = (1 << SEG_BITS) - 1,
    parameter int LOW_W       = CODE_W - SEG_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ser_clk,
    input  logic                         frame_n,
    input  logic                         ser_din,
    input  logic                         dev_addr,
    input  logic                         load_n,
    input  logic                         clear_n,
    output logic                         ser_dout,
    output logic [CHANNELS*CODE_W-1:0]   code_out,
    output logic [CHANNELS*SEG_N-1:0]    seg_en,
    output logic [CHANNELS*LOW_W-1:0]    bin_en
);
    localparam int WORD_W = CODE_W + SEL_W + 1;
    localparam int NPIN   = PIN_COUNT;
    // Idle levels: serial clock high, frame low (no false fall), load and clear inactive.
    localparam logic [NPIN-1:0] PIN_RST =
        NPIN'((1 << PIN_SCLK) | (1 << PIN_LOAD) | (1 << PIN_CLEAR));

    logic [NPIN-1:0]                    pins_raw, pins_s;
    logic [WORD_W-1:0]                  word;
    logic                               word_done;
    logic [CHANNELS-1:0][CODE_W-1:0]    codes;
    logic [CHANNELS-1:0][SEG_N-1:0]     seg_w;
    logic [CHANNELS-1:0][LOW_W-1:0]     bin_w;

    always_comb begin
        pins_raw            = '0;
        pins_raw[PIN_SCLK]  = ser_clk;
        pins_raw[PIN_FRAME] = frame_n;
        pins_raw[PIN_DATA]  = ser_din;
        pins_raw[PIN_ADDR]  = dev_addr;
        pins_raw[PIN_LOAD]  = load_n;
        pins_raw[PIN_CLEAR] = clear_n;
    end

    sol_sync #(.N(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .q     (pins_s)
    );

    sol_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[PIN_SCLK]),
        .frame_s   (pins_s[PIN_FRAME]),
        .sdata_s   (pins_s[PIN_DATA]),
        .word      (word),
        .word_done (word_done),
        .sdout     (ser_dout)
    );

    sol_latch_bank #(.CH(CHANNELS), .CODE_W(CODE_W), .SEL_W(SEL_W), .WORD_W(WORD_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .word      (word),
        .dev_addr  (pins_s[PIN_ADDR]),
        .load_n    (pins_s[PIN_LOAD]),
        .clear_n   (pins_s[PIN_CLEAR]),
        .out_codes (codes)
    );

    sol_segdec #(.CH(CHANNELS), .CODE_W(CODE_W), .SEG_BITS(SEG_BITS),
                 .SEG_N(SEG_N), .LOW_W(LOW_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .codes  (codes),
        .seg_en (seg_w),
        .bin_en (bin_w)
    );

    assign code_out = codes;
    assign seg_en   = seg_w;
    assign bin_en   = bin_w;
endmodule

// File: tb/serial_octal_latch_test.sv
// Self-checking bench for serial_octal_latch: vector table walk, then directed cases.
module serial_octal_latch_test;
    localparam int CH = 8, CW = 12, SEGN = 3, LOWW = 10, WW = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, ser_clk, frame_n, ser_din, dev_addr, load_n, clear_n, ser_dout;
    logic [CH*CW-1:0]   code_out;
    logic [CH*SEGN-1:0] seg_en;
    logic [CH*LOWW-1:0] bin_en;

    serial_octal_latch uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .frame_n(frame_n),
        .ser_din(ser_din), .dev_addr(dev_addr), .load_n(load_n), .clear_n(clear_n),
        .ser_dout(ser_dout), .code_out(code_out), .seg_en(seg_en), .bin_en(bin_en)
    );

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    logic [CW-1:0] exp_in [CH];
    logic [CW-1:0] exp_out[CH];

    // Vector fields: strap, code, address bit, channel.
    typedef struct packed {
        logic          strap;
        logic [CW-1:0] code;
        logic          abit;
        logic [2:0]    ch;
    } vec_t;
    localparam vec_t VECS [8] = '{
        '{1'b0, 12'hABC, 1'b0, 3'd0},
        '{1'b0, 12'h123, 1'b0, 3'd7},
        '{1'b0, 12'hFFF, 1'b1, 3'd0},
        '{1'b1, 12'h5A5, 1'b1, 3'd3},
        '{1'b1, 12'h800, 1'b0, 3'd3},
        '{1'b1, 12'hE01, 1'b1, 3'd5},
        '{1'b0, 12'h7FE, 1'b0, 3'd2},
        '{1'b0, 12'h400, 1'b0, 3'd6}
    };

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [CH*CW-1:0] model_codes();
        logic [CH*CW-1:0] v;
        for (int c = 0; c < CH; c++) v[c*CW +: CW] = exp_out[c];
        return v;
    endfunction

    function automatic logic [CH*SEGN-1:0] model_seg();
        logic [CH*SEGN-1:0] v;
        for (int c = 0; c < CH; c++)
            for (int k = 0; k < SEGN; k++) v[c*SEGN + k] = (int'(exp_out[c][CW-1 -: 2]) > k);
        return v;
    endfunction

    function automatic logic [CH*LOWW-1:0] model_bin();
        logic [CH*LOWW-1:0] v;
        for (int c = 0; c < CH; c++) v[c*LOWW +: LOWW] = exp_out[c][LOWW-1:0];
        return v;
    endfunction

    // One serial bit: fall samples the data, rise follows half a period later.
    task automatic sclk_cycle(input logic d);
        ser_din = d;
        ser_clk = 1'b0;
        wait_n(4);
        ser_clk = 1'b1;
        wait_n(4);
    endtask

    // Send a word, optionally inside a fresh frame, optionally checking the echo (R3).
    task automatic send_word(input logic [WW-1:0] w, input bit framed, input bit echo);
        if (framed) begin
            frame_n = 1'b1; wait_n(4);
            frame_n = 1'b0; wait_n(4);
        end
        for (int i = WW - 1; i >= 0; i--) sclk_cycle(w[i]);
        if (echo) begin
            check(ser_dout == w[WW-1], "R3 echo msb", 128'(ser_dout), 128'(w[WW-1]));
            for (int k = WW - 2; k >= 0; k--) begin
                sclk_cycle(1'b1);   // junk data while locked (R2)
                check(ser_dout == w[k], "R3 echo bit", 128'(ser_dout), 128'(w[k]));
            end
        end
        if (framed) begin
            frame_n = 1'b1; wait_n(4);
        end
    endtask

    task automatic pulse_load();
        load_n = 1'b0; wait_n(4);
        load_n = 1'b1; wait_n(4);
        for (int c = 0; c < CH; c++) exp_out[c] = exp_in[c];
    endtask

    task automatic check_all(input string req);
        check(code_out == model_codes(), req, 128'(code_out), 128'(model_codes()));
        check(seg_en == model_seg(), "R8 seg", 128'(seg_en), 128'(model_seg()));
        check(bin_en == model_bin(), "R8 bin", 128'(bin_en), 128'(model_bin()));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog R9 actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        for (int c = 0; c < CH; c++) begin exp_in[c] = '0; exp_out[c] = '0; end
        rst_n = 1'b0; ser_clk = 1'b1; frame_n = 1'b0; ser_din = 1'b0;
        dev_addr = 1'b0; load_n = 1'b1; clear_n = 1'b1;
        wait_n(6);
        // R9: reset state.
        check(code_out == '0, "R9 reset codes", 128'(code_out), 128'(0));
        check(ser_dout == 1'b0, "R9 reset dout", 128'(ser_dout), 128'(0));
        check(seg_en == '0, "R9 reset seg", 128'(seg_en), 128'(0));
        rst_n = 1'b1;
        wait_n(4);

        // R9: without a frame fall the shifter stays locked; no write, no echo.
        send_word({12'hFFF, 1'b0, 3'd1}, 1'b0, 1'b0);
        pulse_load();
        check(code_out == '0, "R9 locked after reset", 128'(code_out), 128'(0));
        check(ser_dout == 1'b0, "R9 no echo while locked", 128'(ser_dout), 128'(0));

        // Table walk: R1 fields, R4 address match, R5 load, R8 decode.
        for (int v = 0; v < 8; v++) begin
            dev_addr = VECS[v].strap;
            wait_n(4);
            send_word({VECS[v].code, VECS[v].abit, VECS[v].ch}, 1'b1, 1'b1);
            if (VECS[v].abit == VECS[v].strap) exp_in[VECS[v].ch] = VECS[v].code;
            pulse_load();
            check_all("R1 R4 R5 table codes");
        end

        // R5: writes without a load do not move the outputs; one load moves both.
        dev_addr = 1'b0; wait_n(4);
        send_word({12'h9C4, 1'b0, 3'd1}, 1'b1, 1'b0);
        send_word({12'h3D2, 1'b0, 3'd6}, 1'b1, 1'b0);
        exp_in[1] = 12'h9C4; exp_in[6] = 12'h3D2;
        check(code_out == model_codes(), "R5 no load no change", 128'(code_out), 128'(model_codes()));
        pulse_load();
        check_all("R5 simultaneous load");

        // R6: clear zeroes outputs, holds after release, load restores.
        clear_n = 1'b0; wait_n(4);
        check(code_out == '0, "R6 clear", 128'(code_out), 128'(0));
        check(seg_en == '0, "R6 clear seg", 128'(seg_en), 128'(0));
        clear_n = 1'b1; wait_n(4);
        check(code_out == '0, "R6 stays cleared", 128'(code_out), 128'(0));
        pulse_load();
        check(code_out == model_codes(), "R6 restore", 128'(code_out), 128'(model_codes()));

        // R7: clear beats load; releasing clear with load held reloads.
        clear_n = 1'b0; load_n = 1'b0; wait_n(4);
        check(code_out == '0, "R7 clear wins", 128'(code_out), 128'(0));
        clear_n = 1'b1; wait_n(4);
        check(code_out == model_codes(), "R7 load after clear", 128'(code_out), 128'(model_codes()));
        load_n = 1'b1; wait_n(4);

        // R2: extra clocks after capture and a frameless burst change nothing.
        send_word({12'h3C3, 1'b0, 3'd4}, 1'b1, 1'b1);
        exp_in[4] = 12'h3C3;
        send_word({12'h111, 1'b0, 3'd4}, 1'b0, 1'b0);
        pulse_load();
        check_all("R2 lock holds");

        finish_run();
    end
endmodule